// File: doc/BRIEF.md
# Snooping Data-Termination Controller

This block belongs to the control logic of a graphics DRAM device. It watches the command pins on every rising clock edge and recognises read commands aimed at either rank. Chip select plays no part in this decision. Every recognised read is queued for a programmable CAS latency. The block then turns the data-pin on-die termination off for a window whose length follows from the burst length. Reads that overlap merge into one unbroken off period. The snooping only acts when the data termination is programmed for the dual-load setting.

The block also captures the rank configuration once after reset. It takes the CKE level on the first clock edge after reset is released and uses it to set the strength of the address-pin termination. Command and address termination is held on at all times. The data termination value comes from a mode-register field and is passed through unchanged. CAS latency, burst length and termination mode must only be changed while no read window is pending or active.

Top module: `odt_snoop_top`

## Requirements
- R1: A read is decoded on a rising edge when rasN=1, casN=0 and weN=1, whatever the level of csN. Every other combination of the three pins is a non-read.
- R2: In dual-load mode, dqTermEn goes low after the edge that lies casLat-1 edges after the edge on which the read was sampled. casLat may be any value from 4 to 12.
- R3: dqTermEn stays low for BL/2+2 cycles and then returns high. burstLen8=0 selects BL4 and gives 4 cycles. burstLen8=1 selects BL8 and gives 6 cycles.
- R4: dqTermMode encodes the data termination: 2'b00 off, 2'b01 single-load, 2'b10 dual-load (120 ohm), 2'b11 reserved. Only 2'b10 lets reads switch dqTermEn. In any other mode, dqTermEn is held at (dqTermMode != 2'b00).
- R5: cmdTermEn is always 1.
- R6: On the first rising clock edge with rstN high, dualRank takes the CKE level. addrTermHalf is the inverse of dualRank, so a low CKE gives half-strength address termination. Later CKE changes are ignored until the next reset.
- R7: Windows that overlap or touch merge. dqTermEn stays low continuously until the latest window ends.
- R8: Reads on consecutive or nearby cycles each schedule their own window. Two windows separated by a gap show dqTermEn high during the gap.
- R9: While rstN is low, no read is pending, no window is active, dualRank is 0 and addrTermHalf is 1. Reads sampled before a reset never disable termination after it.
- R10: dqTermSel always equals dqTermMode. The rank sampled at reset does not affect it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Device clock |
| rstN | input | 1 | Active-low reset |
| cke | input | 1 | Clock enable, sampled for the rank configuration |
| csN | input | 1 | Chip select, ignored by read snooping |
| rasN | input | 1 | Row strobe command pin |
| casN | input | 1 | Column strobe command pin |
| weN | input | 1 | Write enable command pin |
| casLat | input | 4 | CAS latency in cycles, 4 to 12 |
| burstLen8 | input | 1 | 1 = burst of 8, 0 = burst of 4 |
| dqTermMode | input | 2 | Data termination mode field |
| dqTermEn | output | 1 | Data-pin termination enable |
| cmdTermEn | output | 1 | Command/address termination enable |
| addrTermHalf | output | 1 | Address termination at half strength |
| dualRank | output | 1 | Rank configuration captured after reset |
| dqTermSel | output | 2 | Data termination value selected |

## Verification
The hardest case to reach from the ports is a merge of windows. It needs a second read to land while the first is still in the latency queue or already holding termination off. The table-driven loop therefore issues pairs of reads at chosen gaps: one cycle, two cycles, and a gap wide enough for termination to return between the windows. At each gap the bench compares the full dqTermEn waveform against the union of the two windows it expects. A directed test resets the block while a read is still queued. It then checks that the stale read never disables termination afterwards.

// File: rtl/odt_snoop_pkg.sv
package odt_snoop_pkg;
  localparam logic [1:0] DQ_ODT_OFF    = 2'b00;
  localparam logic [1:0] DQ_ODT_SINGLE = 2'b01;
  localparam logic [1:0] DQ_ODT_DUAL   = 2'b10;

  typedef struct packed {
    logic winStart;   // open or extend the termination-off window
    logic latchRank;  // capture the rank configuration this edge
  } odtStrobe_t;
endpackage

// File: rtl/odt_snoop_ctrl.sv
module odt_snoop_ctrl
  import odt_snoop_pkg::*;
#(
  parameter int MAX_CL = 12,
  parameter int CL_W   = $clog2(MAX_CL + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            csN,
  input  logic            rasN,
  input  logic            casN,
  input  logic            weN,
  input  logic [CL_W-1:0] casLat,
  input  logic [1:0]      dqTermMode,
  output odtStrobe_t      strobe
);
  localparam int DEPTH = MAX_CL - 1;

  logic [DEPTH-1:0] readPipe;
  logic             rankDone;
  logic             cmdMatch;
  logic             readThisRank;
  logic             readOtherRank;
  logic             snoopHit;
  logic             tapHit;

  // a read to this rank and a read to the other rank count alike
  assign cmdMatch      = rasN && !casN && weN;
  assign readThisRank  = !csN && cmdMatch;
  assign readOtherRank = csN && cmdMatch;
  assign snoopHit      = (readThisRank || readOtherRank) && (dqTermMode == DQ_ODT_DUAL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readPipe <= '0;
      rankDone <= 1'b0;
    end else begin
      readPipe <= {readPipe[DEPTH-2:0], snoopHit};
      rankDone <= 1'b1;
    end
  end

  // stage i holds a read sampled i+1 edges ago; open the window casLat-1 edges after it
  always_comb begin
    tapHit = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (int'(casLat) == i + 2) tapHit = readPipe[i];
    end
  end

  assign strobe.winStart  = tapHit;
  assign strobe.latchRank = !rankDone;
endmodule

// File: rtl/odt_snoop_data.sv
module odt_snoop_data
  import odt_snoop_pkg::*;
#(
  parameter int BL_SHORT = 4,
  parameter int BL_LONG  = 8,
  parameter int CNT_W    = $clog2(BL_LONG / 2 + 3)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cke,
  input  logic       burstLen8,
  input  logic [1:0] dqTermMode,
  input  odtStrobe_t strobe,
  output logic       dqTermEn,
  output logic       cmdTermEn,
  output logic       addrTermHalf,
  output logic       dualRank,
  output logic [1:0] dqTermSel
);
  localparam logic [CNT_W-1:0] WIN_SHORT = CNT_W'(BL_SHORT / 2 + 2);
  localparam logic [CNT_W-1:0] WIN_LONG  = CNT_W'(BL_LONG / 2 + 2);

  logic [CNT_W-1:0] offCnt;
  logic [CNT_W-1:0] winLen;
  logic             rankQ;

  assign winLen = burstLen8 ? WIN_LONG : WIN_SHORT;

  // a new window reloads the full length, which always ends at or after the running one
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      offCnt <= '0;
    end else if (strobe.winStart) begin
      offCnt <= winLen;
    end else if (offCnt != '0) begin
      offCnt <= offCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rankQ <= 1'b0;
    end else if (strobe.latchRank) begin
      rankQ <= cke;
    end
  end

  always_comb begin
    if (dqTermMode == DQ_ODT_DUAL) dqTermEn = (offCnt == '0);
    else                           dqTermEn = (dqTermMode != DQ_ODT_OFF);
  end

  assign cmdTermEn    = 1'b1;
  assign dualRank     = rankQ;
  assign addrTermHalf = !rankQ;
  assign dqTermSel    = dqTermMode;
endmodule

// File: rtl/odt_snoop_top.sv
module odt_snoop_top
  import odt_snoop_pkg::*;
#(
  parameter int MAX_CL   = 12,
  parameter int BL_SHORT = 4,
  parameter int BL_LONG  = 8,
  parameter int CL_W     = $clog2(MAX_CL + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cke,
  input  logic            csN,
  input  logic            rasN,
  input  logic            casN,
  input  logic            weN,
  input  logic [CL_W-1:0] casLat,
  input  logic            burstLen8,
  input  logic [1:0]      dqTermMode,
  output logic            dqTermEn,
  output logic            cmdTermEn,
  output logic            addrTermHalf,
  output logic            dualRank,
  output logic [1:0]      dqTermSel
);
  odtStrobe_t strobe;

  odt_snoop_ctrl #(.MAX_CL(MAX_CL), .CL_W(CL_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .casLat(casLat), .dqTermMode(dqTermMode), .strobe(strobe)
  );

  odt_snoop_data #(.BL_SHORT(BL_SHORT), .BL_LONG(BL_LONG)) data_i (
    .clk(clk), .rstN(rstN), .cke(cke), .burstLen8(burstLen8),
    .dqTermMode(dqTermMode), .strobe(strobe), .dqTermEn(dqTermEn),
    .cmdTermEn(cmdTermEn), .addrTermHalf(addrTermHalf), .dualRank(dualRank),
    .dqTermSel(dqTermSel)
  );
endmodule

// File: rtl/odt_snoop_checker.sv
module odt_snoop_checker
  import odt_snoop_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic [1:0] dqTermMode,
  input logic       dqTermEn,
  input logic       cmdTermEn,
  input logic       addrTermHalf,
  input logic       dualRank,
  input logic [1:0] dqTermSel
);
  logic [1:0] sinceRst;
  logic [7:0] offRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceRst <= '0;
      offRun   <= '0;
    end else begin
      if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
      if (dqTermEn) offRun <= '0;
      else if (offRun != 8'hFF) offRun <= offRun + 8'd1;
    end
  end

  p_cmd_term_on_r5: assert property (@(posedge clk) disable iff (!rstN) cmdTermEn);

  p_addr_half_r6: assert property (@(posedge clk) disable iff (!rstN)
    addrTermHalf != dualRank);

  p_rank_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3) |-> $stable(dualRank));

  p_mode_gate_r4: assert property (@(posedge clk) disable iff (!rstN)
    (dqTermMode != DQ_ODT_DUAL) |-> (dqTermEn == (dqTermMode != DQ_ODT_OFF)));

  p_window_min_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(dqTermEn) && $stable(dqTermMode) && dqTermMode == DQ_ODT_DUAL) |-> (offRun >= 8'd4));

  p_sel_follow_r10: assert property (@(posedge clk) disable iff (!rstN)
    dqTermSel == dqTermMode);
endmodule

bind odt_snoop_top odt_snoop_checker chk_i (
  .clk(clk), .rstN(rstN), .dqTermMode(dqTermMode), .dqTermEn(dqTermEn),
  .cmdTermEn(cmdTermEn), .addrTermHalf(addrTermHalf), .dualRank(dualRank),
  .dqTermSel(dqTermSel)
);

// File: tb/odt_snoop_top_tb_top.sv
`timescale 1ns/1ps
module odt_snoop_top_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cke = 1'b0;
  logic csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1;
  logic [3:0] casLat = 4'd5;
  logic burstLen8 = 1'b0;
  logic [1:0] dqTermMode = 2'b10;
  logic dqTermEn, cmdTermEn, addrTermHalf, dualRank;
  logic [1:0] dqTermSel;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  odt_snoop_top dut_i (
    .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .casLat(casLat), .burstLen8(burstLen8), .dqTermMode(dqTermMode),
    .dqTermEn(dqTermEn), .cmdTermEn(cmdTermEn), .addrTermHalf(addrTermHalf),
    .dualRank(dualRank), .dqTermSel(dqTermSel)
  );

  // cl, bl8, mode, csN, rasN, casN, weN, gap (0 = single command, else second read this many edges later)
  typedef struct packed {
    logic [3:0] cl;
    logic       bl8;
    logic [1:0] mode;
    logic       cs;
    logic       ras;
    logic       cas;
    logic       we;
    logic [3:0] gap;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{4'd4,  1'b0, 2'b10, 1'b0, 1'b1, 1'b0, 1'b1, 4'd0}, // R1 R2 R3 min latency
    '{4'd12, 1'b1, 2'b10, 1'b1, 1'b1, 1'b0, 1'b1, 4'd0}, // R1 other rank, max latency
    '{4'd7,  1'b1, 2'b10, 1'b0, 1'b1, 1'b0, 1'b1, 4'd0}, // R2 R3 BL8
    '{4'd5,  1'b0, 2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0}, // R1 write: no effect
    '{4'd5,  1'b0, 2'b10, 1'b0, 1'b0, 1'b1, 1'b1, 4'd0}, // R1 activate: no effect
    '{4'd5,  1'b0, 2'b10, 1'b1, 1'b1, 1'b1, 1'b1, 4'd0}, // R1 nop: no effect
    '{4'd6,  1'b0, 2'b01, 1'b0, 1'b1, 1'b0, 1'b1, 4'd0}, // R4 single-load
    '{4'd6,  1'b1, 2'b00, 1'b0, 1'b1, 1'b0, 1'b1, 4'd0}, // R4 off
    '{4'd8,  1'b1, 2'b11, 1'b1, 1'b1, 1'b0, 1'b1, 4'd0}, // R4 reserved
    '{4'd9,  1'b0, 2'b10, 1'b1, 1'b1, 1'b0, 1'b1, 4'd0}, // R2 R3
    '{4'd5,  1'b0, 2'b10, 1'b0, 1'b1, 1'b0, 1'b1, 4'd1}, // R7 R8 back to back
    '{4'd5,  1'b0, 2'b10, 1'b1, 1'b1, 1'b0, 1'b1, 4'd2}, // R7 overlap
    '{4'd6,  1'b0, 2'b10, 1'b0, 1'b1, 1'b0, 1'b1, 4'd4}, // R7 touching windows
    '{4'd4,  1'b1, 2'b10, 1'b0, 1'b1, 1'b0, 1'b1, 4'd8}  // R8 separated windows
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic nop();
    csN = 1'b1; rasN = 1'b1; casN = 1'b1; weN = 1'b1;
  endtask

  task automatic doReset(input logic ckeVal);
    @(negedge clk);
    rstN = 1'b0;
    nop();
    cke = ckeVal;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // checks the whole dqTermEn waveform for one vector against the expected windows
  task automatic runVec(input vec_t v, input int idx);
    bit isRd;
    bit dualMode;
    int len;
    int bad = 0;
    int badK = -1;
    logic badAct = 1'b0;
    logic badExp = 1'b0;
    casLat = v.cl; burstLen8 = v.bl8; dqTermMode = v.mode;
    nop();
    repeat (3) @(negedge clk);
    isRd = v.ras && !v.cas && v.we;
    dualMode = (v.mode == 2'b10);
    len = v.bl8 ? 6 : 4;
    csN = v.cs; rasN = v.ras; casN = v.cas; weN = v.we;
    for (int k = 0; k < 32; k++) begin
      logic expEn;
      bit off0;
      bit off1;
      @(posedge clk);
      @(negedge clk);
      off0 = isRd && dualMode && (k >= int'(v.cl) - 1) && (k < int'(v.cl) - 1 + len);
      off1 = (v.gap != 0) && dualMode && (k >= int'(v.gap) + int'(v.cl) - 1)
             && (k < int'(v.gap) + int'(v.cl) - 1 + len);
      expEn = dualMode ? !(off0 || off1) : (v.mode != 2'b00);
      if (dqTermEn !== expEn && badK < 0) begin
        badK = k; badAct = dqTermEn; badExp = expEn;
      end
      if (dqTermEn !== expEn) bad++;
      if (v.gap != 0 && k + 1 == int'(v.gap)) begin
        csN = v.cs; rasN = 1'b1; casN = 1'b0; weN = 1'b1;
      end else begin
        nop();
      end
    end
    tests++;
    if (bad != 0) begin
      fails++;
      $display("FAIL R1/R2/R3/R4/R7/R8 vector %0d cycle %0d dqTermEn actual=%b expected=%b",
               idx, badK, badAct, badExp);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R9 reset state
    repeat (2) @(negedge clk);
    check(dualRank == 1'b0, "R9", "dualRank in reset", dualRank, 0);
    check(addrTermHalf == 1'b1, "R9", "addrTermHalf in reset", addrTermHalf, 1);
    check(dqTermEn == 1'b1, "R9", "dqTermEn in reset", dqTermEn, 1);

    // R6 single rank
    doReset(1'b0);
    check(dualRank == 1'b0, "R6", "dualRank cke low", dualRank, 0);
    check(addrTermHalf == 1'b1, "R6", "addrTermHalf cke low", addrTermHalf, 1);
    cke = 1'b1;
    repeat (3) @(negedge clk);
    check(dualRank == 1'b0, "R6", "dualRank after cke toggle", dualRank, 0);

    // R6 dual rank
    doReset(1'b1);
    check(dualRank == 1'b1, "R6", "dualRank cke high", dualRank, 1);
    check(addrTermHalf == 1'b0, "R6", "addrTermHalf cke high", addrTermHalf, 0);
    cke = 1'b0;
    repeat (3) @(negedge clk);
    check(dualRank == 1'b1, "R6", "dualRank after cke drop", dualRank, 1);
    check(cmdTermEn == 1'b1, "R5", "cmdTermEn dual rank", cmdTermEn, 1);

    // R10 selection follows the mode field, not the rank
    for (int m = 0; m < 4; m++) begin
      dqTermMode = 2'(m);
      @(negedge clk);
      check(dqTermSel == 2'(m), "R10", "dqTermSel", dqTermSel, m);
    end

    for (int i = 0; i < NVEC; i++) runVec(VECS[i], i);
    check(cmdTermEn == 1'b1, "R5", "cmdTermEn after reads", cmdTermEn, 1);

    // R9 a queued read is dropped by reset
    begin
      int lows = 0;
      dqTermMode = 2'b10; casLat = 4'd8; burstLen8 = 1'b1;
      @(negedge clk);
      csN = 1'b0; rasN = 1'b1; casN = 1'b0; weN = 1'b1;
      @(negedge clk);
      nop();
      @(negedge clk);
      rstN = 1'b0;
      @(negedge clk);
      rstN = 1'b1;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (!dqTermEn) lows++;
      end
      check(lows == 0, "R9", "low cycles after reset", lows, 0);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule